// File: doc/BRIEF.md
# Four-Source Interrupt Capture Unit

This block takes four external interrupt request lines, which are asynchronous to the core clock. It turns them into per-source pending flags for a processor core. Each line is first resynchronized. It is then detected in one of two modes, chosen per source by a configuration register. In edge mode a low-to-high transition raises the request. In level mode a high sample raises it. A short per-source lockout limits how often the same source can be accepted.

The core raises `ack_i` when it wants to take an interrupt. The block then grants the lowest-numbered pending source and clears only that source's flag. After that it runs a two-phase response. First comes a vector-read cycle, in which the vector address is a fixed base plus the source index. Then comes a first-fetch cycle. After the fetch cycle the block is ready for the next acknowledge. A level source held high is accepted again every second cycle. A short level pulse is therefore taken once, and a long one is taken repeatedly. An edge source held high is taken once, however long it is held.

Top module: `irq_capture_unit`

## Requirements
- R1: While `rst_ni` is low, and after its release until the first configuration write, `pend_o`, `irq_o`, `vec_rd_o` and `fetch_o` are all 0. Both the mode bits and the enable bits reset to 0.
- R2: Each request passes through two synchronizer flops. If a request is driven high between two clock edges, the matching `pend_o` bit rises after the third rising edge, and not before.
- R3: In edge mode (configuration bit 1), a synchronized low-to-high transition is accepted once. Holding the line high any number of cycles produces no further acceptance.
- R4: In level mode (configuration bit 0), a source that is high for N consecutive synchronized samples is accepted on the first sample and then on every second sample, which is ceil(N/2) acceptances. So a 1- or 2-sample pulse is taken once, and a 3-sample pulse is taken twice.
- R5: After a source is accepted, it cannot be accepted again on the next clock edge. It can be accepted again two edges after the acceptance.
- R6: A source whose enable bit is 0 sets no new pending flag. A flag that is already set stays set.
- R7: `irq_o` is the OR of `pend_o`. On an acknowledge while idle with any flag set, the lowest-index pending source is granted and only its flag is cleared. A new acceptance of that same source on the same edge keeps its flag set.
- R8: The cycle after a grant, `vec_rd_o` is high for exactly one cycle. During that cycle `vec_addr_o` equals `VEC_BASE` plus the granted index, and `ack_id_o` equals that index.
- R9: `fetch_o` is high for exactly the one cycle after the vector-read cycle, and the block is idle after it. An acknowledge during the vector-read or fetch cycle is ignored.
- R10: When `cfg_we_i` is high at a clock edge, bit i of `cfg_edge_i` becomes the mode of source i (1 = edge, 0 = level) and bit i of `cfg_en_i` becomes its enable. The new values govern detection from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | 4 | Asynchronous interrupt request lines |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_edge_i | input | 4 | Per-source mode to write (1 = edge, 0 = level) |
| cfg_en_i | input | 4 | Per-source enable to write |
| ack_i | input | 1 | Core acknowledge request |
| pend_o | output | 4 | Per-source pending flags |
| irq_o | output | 1 | Any source pending |
| vec_rd_o | output | 1 | Vector-read phase active |
| vec_addr_o | output | 8 | Vector address, valid during the vector-read phase |
| fetch_o | output | 1 | First-fetch phase active |
| ack_id_o | output | 2 | Index of the source last granted |

## Verification
The bench drives level pulses of one to five samples while acknowledging at once, and counts the vector-read cycles that result. A missing lockout would give one grant per sample. A lockout that is too long would give only one grant for a long hold. An edge source is held for many cycles to show that it is taken once. A latency probe detects a missing or extra synchronizer stage. Simultaneous requests check the priority order, the vector address and clearing of a single flag. Random stimulus with random acknowledges, including acknowledges during the busy phases, hits the case where a flag is cleared and set again on the same edge. A design that let the clear win there would lose an interrupt.

// File: rtl/irq_cap_pkg.sv
package irq_cap_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_VREAD = 2'd1,
    PH_FETCH = 2'd2
  } resp_phase_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= {q[STAGES-2:0], async_i};
  end

  assign sync_o = q[STAGES-1];
endmodule

// File: rtl/irq_lane.sv
module irq_lane #(
  parameter int LOCK_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic smp_i,
  input  logic edge_mode_i,
  input  logic en_i,
  input  logic clr_i,
  output logic pend_o,
  output logic accept_o
);
  localparam int LCW = (LOCK_CYC > 1) ? $clog2(LOCK_CYC) : 1;
  localparam logic [LCW-1:0] LOCK_LOAD = LCW'(LOCK_CYC - 1);

  logic           prev_q;
  logic           pend_q;
  logic [LCW-1:0] lock_q;
  logic           rise, det, locked;

  assign rise     = smp_i & ~prev_q;
  assign det      = edge_mode_i ? rise : smp_i;
  assign locked   = (lock_q != '0);
  assign accept_o = det & en_i & ~locked;
  assign pend_o   = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
      lock_q <= '0;
    end else begin
      prev_q <= smp_i;
      // a new acceptance wins over a same-edge clear
      pend_q <= (pend_q & ~clr_i) | accept_o;
      if (accept_o)    lock_q <= LOCK_LOAD;
      else if (locked) lock_q <= lock_q - LCW'(1);
    end
  end

  if (LOCK_CYC >= 2) begin : g_lock_chk
    a_r5_lockout: assert property (@(posedge clk_i) disable iff (!rst_ni)
      accept_o |=> !accept_o);
  end

  a_r6_disabled_no_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !pend_q) |=> !pend_q);

  a_r3_edge_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode_i && smp_i && prev_q) |-> !accept_o);

  a_r7_clear_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !accept_o) |=> !pend_o);
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int N_SRC = 4,
  parameter int IDW   = 2
) (
  input  logic [N_SRC-1:0] req_i,
  output logic             any_o,
  output logic [IDW-1:0]   id_o
);
  always_comb begin
    id_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) id_o = IDW'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/irq_resp_seq.sv
module irq_resp_seq
  import irq_cap_pkg::*;
#(
  parameter int             IDW      = 2,
  parameter int             VEC_W    = 8,
  parameter logic [VEC_W-1:0] VEC_BASE = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ack_i,
  input  logic             any_i,
  input  logic [IDW-1:0]   id_i,
  output logic             grant_o,
  output logic [IDW-1:0]   id_o,
  output logic             vec_rd_o,
  output logic             fetch_o,
  output logic [VEC_W-1:0] vec_addr_o
);
  resp_phase_e    phase_q, phase_d;
  logic [IDW-1:0] id_q;

  assign grant_o = ack_i & any_i & (phase_q == PH_IDLE);

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:  if (grant_o) phase_d = PH_VREAD;
      PH_VREAD: phase_d = PH_FETCH;
      PH_FETCH: phase_d = PH_IDLE;
      default:  phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      id_q    <= '0;
    end else begin
      phase_q <= phase_d;
      if (grant_o) id_q <= id_i;
    end
  end

  assign id_o       = id_q;
  assign vec_rd_o   = (phase_q == PH_VREAD);
  assign fetch_o    = (phase_q == PH_FETCH);
  assign vec_addr_o = VEC_BASE + VEC_W'(id_q);

  a_r8_vread_after_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |=> (vec_rd_o && id_o == $past(id_i)));

  a_r9_fetch_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_rd_o |=> (fetch_o && !vec_rd_o));

  a_r9_idle_after_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_o |=> (!fetch_o && !vec_rd_o));

  a_r8_phase_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(vec_rd_o && fetch_o));
endmodule

// File: rtl/irq_capture_unit.sv
module irq_capture_unit #(
  parameter int               N_SRC       = 4,
  parameter int               SYNC_STAGES = 2,
  parameter int               LOCK_CYC    = 2,
  parameter int               VEC_W       = 8,
  parameter logic [VEC_W-1:0] VEC_BASE    = 8'h40,
  localparam int              IDW         = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] irq_req_i,
  input  logic             cfg_we_i,
  input  logic [N_SRC-1:0] cfg_edge_i,
  input  logic [N_SRC-1:0] cfg_en_i,
  input  logic             ack_i,
  output logic [N_SRC-1:0] pend_o,
  output logic             irq_o,
  output logic             vec_rd_o,
  output logic [VEC_W-1:0] vec_addr_o,
  output logic             fetch_o,
  output logic [IDW-1:0]   ack_id_o
);
  logic [N_SRC-1:0] edge_q, en_q;
  logic [N_SRC-1:0] smp, acc, clr;
  logic             any, grant;
  logic [IDW-1:0]   win_id;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_q <= '0;
      en_q   <= '0;
    end else if (cfg_we_i) begin
      edge_q <= cfg_edge_i;
      en_q   <= cfg_en_i;
    end
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (irq_req_i[i]),
      .sync_o  (smp[i])
    );

    assign clr[i] = grant && (win_id == IDW'(i));

    irq_lane #(.LOCK_CYC(LOCK_CYC)) u_lane (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .smp_i       (smp[i]),
      .edge_mode_i (edge_q[i]),
      .en_i        (en_q[i]),
      .clr_i       (clr[i]),
      .pend_o      (pend_o[i]),
      .accept_o    (acc[i])
    );
  end

  irq_prio #(.N_SRC(N_SRC), .IDW(IDW)) u_prio (
    .req_i (pend_o),
    .any_o (any),
    .id_o  (win_id)
  );

  irq_resp_seq #(.IDW(IDW), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ack_i      (ack_i),
    .any_i      (any),
    .id_i       (win_id),
    .grant_o    (grant),
    .id_o       (ack_id_o),
    .vec_rd_o   (vec_rd_o),
    .fetch_o    (fetch_o),
    .vec_addr_o (vec_addr_o)
  );

  assign irq_o = any;

  a_r9_busy_no_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_rd_o || fetch_o) |-> !grant);

  a_r7_single_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant |=> ($countones($past(pend_o) & ~pend_o) <= 1));

  a_r6_no_accept_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc & ~en_q) == '0);
endmodule

// File: tb/irq_capture_unit_test.sv
module irq_capture_unit_test;
  localparam logic [7:0] BASE = 8'h40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] irq = '0;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_edge = '0, cfg_en = '0;
  logic       ack = 1'b0;
  logic [3:0] pend;
  logic       irq_any, vec_rd, fetch;
  logic [7:0] vec_addr;
  logic [1:0] ack_id;

  int  checks = 0, errors = 0, cyc = 0, n_vr = 0;
  bit  auto_ack = 1'b0, done = 1'b0;

  always #10 clk = ~clk;

  irq_capture_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(irq), .cfg_we_i(cfg_we),
    .cfg_edge_i(cfg_edge), .cfg_en_i(cfg_en), .ack_i(ack), .pend_o(pend),
    .irq_o(irq_any), .vec_rd_o(vec_rd), .vec_addr_o(vec_addr),
    .fetch_o(fetch), .ack_id_o(ack_id)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int lowest(input logic [3:0] v);
    for (int i = 0; i < 4; i++) if (v[i]) return i;
    return 0;
  endfunction

  // requirement-level reference model
  logic [3:0] m_s1, m_s2, m_prv, m_pend, m_edge, m_en, m_lk;
  logic [1:0] m_ph, m_id;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_prv <= '0; m_pend <= '0;
      m_edge <= '0; m_en <= '0; m_lk <= '0; m_ph <= '0; m_id <= '0;
    end else begin
      logic [3:0] acc, clr;
      logic       g;
      for (int i = 0; i < 4; i++) begin
        logic d;
        d = m_edge[i] ? (m_s2[i] & ~m_prv[i]) : m_s2[i];
        acc[i] = d & m_en[i] & ~m_lk[i];
      end
      g   = (m_ph == 2'd0) && ack && (m_pend != 0);
      clr = g ? (4'b1 << lowest(m_pend)) : 4'b0;
      m_pend <= (m_pend & ~clr) | acc;
      m_lk   <= acc;
      if (g) m_id <= 2'(lowest(m_pend));
      m_ph <= (m_ph == 2'd0) ? (g ? 2'd1 : 2'd0) : (m_ph == 2'd1 ? 2'd2 : 2'd0);
      if (cfg_we) begin m_edge <= cfg_edge; m_en <= cfg_en; end
      m_s1 <= irq; m_s2 <= m_s1; m_prv <= m_s2;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R3/R4/R5/R6 pend_o vs model", 32'(pend), 32'(m_pend));
      check("R7 irq_o vs model", 32'(irq_any), 32'(|m_pend));
      check("R8 vec_rd_o vs model", 32'(vec_rd), 32'(m_ph == 2'd1));
      check("R9 fetch_o vs model", 32'(fetch), 32'(m_ph == 2'd2));
      if (vec_rd) check("R8 vec_addr_o vs model", 32'(vec_addr), 32'(BASE + 8'(m_id)));
    end
  end

  task automatic step();
    @(negedge clk);
    if (vec_rd) n_vr++;
    if (auto_ack) ack = irq_any;
  endtask

  task automatic cfg(input logic [3:0] e, input logic [3:0] en);
    cfg_we = 1'b1; cfg_edge = e; cfg_en = en;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic pulse_count(input int src, input int n, input int exp, input string tag);
    n_vr = 0;
    irq[src] = 1'b1;
    repeat (n) step();
    irq[src] = 1'b0;
    repeat (14) step();
    check(tag, 32'(n_vr), 32'(exp));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) step();
    check("R1 pend_o in reset", 32'(pend), 0);
    check("R1 irq_o in reset", 32'(irq_any), 0);
    check("R1 vec_rd_o/fetch_o in reset", 32'({vec_rd, fetch}), 0);
    rst_n = 1'b1;
    irq = 4'hF;
    repeat (6) step();
    check("R1 disabled after reset", 32'(pend), 0);
    irq = '0;
    repeat (3) step();

    // R10: all level, all enabled
    cfg(4'b0000, 4'b1111);

    // R2 latency
    irq = 4'b0010;
    step(); check("R2 after edge 1", 32'(pend[1]), 0);
    step(); check("R2 after edge 2", 32'(pend[1]), 0);
    step(); check("R2 after edge 3", 32'(pend[1]), 1);
    irq = '0;
    auto_ack = 1'b1;
    repeat (12) step();

    // R4/R5 level pulse widths
    pulse_count(2, 1, 1, "R4 level 1 sample grants");
    pulse_count(2, 2, 1, "R4 level 2 samples grants");
    pulse_count(2, 3, 2, "R4 R5 level 3 samples grants");
    pulse_count(2, 4, 2, "R4 level 4 samples grants");
    pulse_count(2, 5, 3, "R4 R5 level 5 samples grants");

    // R3/R10 edge mode on source 3
    cfg(4'b1000, 4'b1111);
    pulse_count(3, 9, 1, "R3 R10 edge held 9 grants");
    pulse_count(3, 1, 1, "R3 edge 1 sample grants");

    // R6 disabled source 0
    cfg(4'b0000, 4'b1110);
    pulse_count(0, 3, 0, "R6 disabled source grants");

    // R7/R8/R9 priority
    cfg(4'b0000, 4'b1111);
    auto_ack = 1'b0; ack = 1'b0;
    irq = 4'b1010; step(); irq = '0;
    repeat (5) step();
    check("R7 both pending", 32'(pend), 32'b1010);
    ack = 1'b1; step(); ack = 1'b0;
    check("R8 vec_rd after grant", 32'(vec_rd), 1);
    check("R8 vec addr source 1", 32'(vec_addr), 32'(BASE + 8'd1));
    check("R8 ack_id source 1", 32'(ack_id), 1);
    check("R7 only source 1 cleared", 32'(pend), 32'b1000);
    ack = 1'b1; step();
    check("R9 fetch after vread", 32'(fetch), 1);
    step();
    check("R9 ack ignored while busy", 32'({vec_rd, pend}), 32'b01000);
    step(); ack = 1'b0;
    check("R8 vec addr source 3", 32'(vec_addr), 32'(BASE + 8'd3));
    check("R7 all cleared", 32'(pend), 0);
    repeat (4) step();

    // random phase
    for (int k = 0; k < 3000; k++) begin
      irq = 4'($urandom);
      ack = ($urandom % 3) == 0;
      if (($urandom % 97) == 0) begin
        cfg_we = 1'b1; cfg_edge = 4'($urandom); cfg_en = 4'($urandom) | 4'b0100;
      end else cfg_we = 1'b0;
      step();
    end
    cfg_we = 1'b0; irq = '0; ack = 1'b0;
    repeat (5) step();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule